// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Pin Interrupts

This block is a general-purpose I/O peripheral reached through an APB slave port. It holds up to four ports of pins. Every port has an output-value register, a direction register and a read-only view of its pin levels. Only the first port (port A) can raise interrupts. Each of its pins has an enable, a mask, a trigger type (edge or level), a trigger polarity and an optional debounce filter. Edge events are latched until software clears them through a write-one-to-clear register. A single interrupt line is the OR of all visible status bits.

Pin inputs pass through a two-flop synchronizer before the block reads them or uses them for interrupts. Debounce is paced by a one-cycle sample strobe, `db_tick`, which the system supplies in the APB clock domain. Register writes take effect on the APB access-phase clock edge. Read data is a function of the address and is valid during the access phase.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: After reset every register reads 0, no pin is driven (`pin_oe` all 0), `pin_out` is 0 and `irq` is low.
- R2: Port p (0..3) has its output-value register at byte offset 12*p and its direction register at 12*p+4, both read/write. Bit i of `pin_oe` for that port equals its direction bit, and bit i of `pin_out` equals its output-value bit.
- R3: The pin-level register of port p sits at 0x50+4*p. It returns that port's pins after two-flop synchronization and ignores writes.
- R4: A port A pin whose type bit (offset 0x38) is 0 is level-triggered. Polarity bit (0x3C) 1 means active high and 0 means active low. Its status bit follows the pin and is not latched.
- R5: A pin whose enable bit (0x30) is 0 never sets its status bit and never raises `irq`.
- R6: A pin whose type bit is 1 is edge-triggered. Polarity 1 catches a rising edge and polarity 0 a falling edge. The event is latched and stays after the pin returns.
- R7: Writing to offset 0x4C clears the latched edge event of every pin whose data bit is 1. Pins written with 0 keep their pending event. The register reads 0.
- R8: A mask bit (0x34) of 1 hides the pin from the status register (0x40) and from `irq` without discarding a latched event, which reappears once unmasked. `irq` is high exactly when some status bit is set.
- R9: When a pin's debounce bit (0x48) is 1, a change on that pin reaches the interrupt logic only after it has been sampled at the same new value on two consecutive `db_tick` strobes. A pulse that does not last across two strobes is not seen.
- R10: Offsets that map to no register, including unaligned ones, read as 0 and ignore writes. The status register is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1, read when 0 |
| paddr | input | 7 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| db_tick | input | 1 | Debounce sample strobe, one pclk cycle wide |
| pin_in | input | 128 | Pin levels, port p in bits 32*p+31 .. 32*p |
| pin_out | output | 128 | Output values toward the pads |
| pin_oe | output | 128 | Output enables toward the pads |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `db_tick` is held low throughout reset. They also assume that an APB write is a proper setup-then-access pair, with `psel` and `penable` both high for exactly one edge per transfer. The bench drives every bus transfer through a task that follows this shape, and it drives pins and strobes only on falling clock edges. Each pin change is given at least three cycles to cross the synchronizer before the bench looks at status, so a correct design never shows a half-propagated value.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;

  localparam int OFS_INT_EN   = 'h30;
  localparam int OFS_INT_MASK = 'h34;
  localparam int OFS_INT_TYPE = 'h38;
  localparam int OFS_INT_POL  = 'h3C;
  localparam int OFS_INT_STAT = 'h40;
  localparam int OFS_DEB_EN   = 'h48;
  localparam int OFS_EOI      = 'h4C;
  localparam int OFS_LVL_BASE = 'h50;
  localparam int PORT_STRIDE  = 12;

  function automatic int dout_ofs(input int p);
    return PORT_STRIDE * p;
  endfunction

  function automatic int dir_ofs(input int p);
    return PORT_STRIDE * p + 4;
  endfunction

  function automatic int lvl_ofs(input int p);
    return OFS_LVL_BASE + 4 * p;
  endfunction

  // Trigger condition for one pin: edge event or active level.
  function automatic logic trig_bit(input logic is_edge, input logic pol,
                                    input logic cur, input logic prev);
    if (is_edge) return pol ? (cur & ~prev) : (~cur & prev);
    return pol ? cur : ~cur;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_apb_pkg::*;
#(
  parameter int W      = 32,
  parameter int NP     = 4,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [NP*W-1:0]   dout,
  output logic [NP*W-1:0]   dir
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    logic wr_dout, wr_dir;
    assign wr_dout = wr && (addr == ADDR_W'(dout_ofs(p)));
    assign wr_dir  = wr && (addr == ADDR_W'(dir_ofs(p)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dout[p*W +: W] <= '0;
        dir[p*W +: W]  <= '0;
      end else begin
        if (wr_dout) dout[p*W +: W] <= wdata;
        if (wr_dir)  dir[p*W +: W]  <= wdata;
      end
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_apb_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic         db_tick,
  input  logic [W-1:0] en,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] typ,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] deb,
  input  logic         eoi_wr,
  input  logic [W-1:0] eoi_mask,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] filt_v, pend_v, hit_v, raw_v;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic db_last, prev, q, clr;
    assign q        = deb[i] ? filt_v[i] : pin_s[i];
    assign clr      = eoi_wr & eoi_mask[i];
    assign hit_v[i] = typ[i] & trig_bit(1'b1, pol[i], q, prev);
    assign raw_v[i] = typ[i] ? pend_v[i] : trig_bit(1'b0, pol[i], q, prev);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        db_last   <= 1'b0;
        filt_v[i] <= 1'b0;
        prev      <= 1'b0;
        pend_v[i] <= 1'b0;
      end else begin
        if (db_tick) begin
          db_last <= pin_s[i];
          if (pin_s[i] == db_last) filt_v[i] <= pin_s[i];
        end
        prev      <= q;
        pend_v[i] <= en[i] & typ[i] & (hit_v[i] | (pend_v[i] & ~clr));
      end
    end
  end

  assign status = raw_v & en & ~mask;
  assign irq    = |status;

  // R6: a pending bit only appears after an edge hit in the previous cycle
  p_pend_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_v & ~$past(pend_v) & ~$past(hit_v)) == '0));

  // R7: cleared bits stay clear unless a new edge arrived alongside the write
  p_eoi_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> ((pend_v & $past(eoi_mask & ~hit_v)) == '0));

  // R9: the debounce filter only moves on a sample strobe
  p_debounce_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(db_tick) |-> (filt_v == $past(filt_v)));
endmodule

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl
  import gpio_apb_pkg::*;
#(
  parameter int W      = 32,
  parameter int NP     = 4,
  parameter int ADDR_W = 7
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              db_tick,
  input  logic [NP*W-1:0]   pin_in,
  output logic [NP*W-1:0]   pin_out,
  output logic [NP*W-1:0]   pin_oe,
  output logic              irq
);
  localparam int TOTAL = NP * W;

  logic              wr;
  logic [W-1:0]      wd;
  logic [TOTAL-1:0]  pin_s;
  logic [W-1:0]      int_en_q, int_mask_q, int_type_q, int_pol_q, deb_q;
  logic [W-1:0]      status;
  logic              eoi_wr;

  assign wr     = psel & penable & pwrite;
  assign wd     = pwdata[W-1:0];
  assign eoi_wr = wr && (paddr == ADDR_W'(OFS_EOI));

  gpio_in_sync #(.N(TOTAL)) u_sync (
    .clk(pclk), .rst_n(presetn), .d(pin_in), .q(pin_s)
  );

  gpio_port_bank #(.W(W), .NP(NP), .ADDR_W(ADDR_W)) u_bank (
    .clk(pclk), .rst_n(presetn), .wr(wr), .addr(paddr), .wdata(wd),
    .dout(pin_out), .dir(pin_oe)
  );

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      int_en_q   <= '0;
      int_mask_q <= '0;
      int_type_q <= '0;
      int_pol_q  <= '0;
      deb_q      <= '0;
    end else if (wr) begin
      if (paddr == ADDR_W'(OFS_INT_EN))   int_en_q   <= wd;
      if (paddr == ADDR_W'(OFS_INT_MASK)) int_mask_q <= wd;
      if (paddr == ADDR_W'(OFS_INT_TYPE)) int_type_q <= wd;
      if (paddr == ADDR_W'(OFS_INT_POL))  int_pol_q  <= wd;
      if (paddr == ADDR_W'(OFS_DEB_EN))   deb_q      <= wd;
    end
  end

  gpio_irq_ctrl #(.W(W)) u_irq (
    .clk(pclk), .rst_n(presetn), .pin_s(pin_s[W-1:0]), .db_tick(db_tick),
    .en(int_en_q), .mask(int_mask_q), .typ(int_type_q), .pol(int_pol_q),
    .deb(deb_q), .eoi_wr(eoi_wr), .eoi_mask(wd),
    .status(status), .irq(irq)
  );

  always_comb begin
    prdata = '0;
    for (int p = 0; p < NP; p++) begin
      if (paddr == ADDR_W'(dout_ofs(p))) prdata[W-1:0] = pin_out[p*W +: W];
      if (paddr == ADDR_W'(dir_ofs(p)))  prdata[W-1:0] = pin_oe[p*W +: W];
      if (paddr == ADDR_W'(lvl_ofs(p)))  prdata[W-1:0] = pin_s[p*W +: W];
    end
    if (paddr == ADDR_W'(OFS_INT_EN))   prdata[W-1:0] = int_en_q;
    if (paddr == ADDR_W'(OFS_INT_MASK)) prdata[W-1:0] = int_mask_q;
    if (paddr == ADDR_W'(OFS_INT_TYPE)) prdata[W-1:0] = int_type_q;
    if (paddr == ADDR_W'(OFS_INT_POL))  prdata[W-1:0] = int_pol_q;
    if (paddr == ADDR_W'(OFS_INT_STAT)) prdata[W-1:0] = status;
    if (paddr == ADDR_W'(OFS_DEB_EN))   prdata[W-1:0] = deb_q;
  end

  // R2: a write to the port A direction register shows on the enables next cycle
  p_dir_drive_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && paddr == ADDR_W'(dir_ofs(0))) |=> (pin_oe[W-1:0] == $past(wd)));

  // R5: with every enable bit clear the interrupt line stays low
  p_irq_quiet_r5: assert property (@(posedge pclk) disable iff (!presetn)
    (int_en_q == '0) |-> !irq);
endmodule

// File: tb/gpio_apb_ctrl_test.sv
module gpio_apb_ctrl_test;
  logic         pclk = 1'b0;
  logic         presetn = 1'b0;
  logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [6:0]   paddr = '0;
  logic [31:0]  pwdata = '0;
  logic [31:0]  prdata;
  logic         db_tick = 1'b0;
  logic [127:0] pins = '0;
  logic [127:0] pin_out, pin_oe;
  logic         irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 pclk = ~pclk;

  gpio_apb_ctrl uut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .db_tick(db_tick), .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge pclk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic tick();
    @(negedge pclk); db_tick = 1'b1;
    @(negedge pclk); db_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(7'h00, v); check("R1 dout A", v, 0);
    rd(7'h04, v); check("R1 dir A", v, 0);
    rd(7'h30, v); check("R1 int enable", v, 0);
    rd(7'h40, v); check("R1 status", v, 0);
    check("R1 pin_oe", {31'b0, |pin_oe}, 0);
    check("R1 pin_out", {31'b0, |pin_out}, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_data_dir();
    logic [31:0] v;
    wr(7'h00, 32'hA5A5_0F0F);
    wr(7'h04, 32'hFFFF_0000);
    check("R2 pin_out A", pin_out[31:0], 32'hA5A5_0F0F);
    check("R2 pin_oe A", pin_oe[31:0], 32'hFFFF_0000);
    wr(7'h18, 32'h1234_5678);
    wr(7'h1C, 32'h0000_FFFF);
    check("R2 pin_out C", pin_out[95:64], 32'h1234_5678);
    check("R2 pin_oe C", pin_oe[95:64], 32'h0000_FFFF);
    check("R2 pin_out B untouched", pin_out[63:32], 0);
    rd(7'h18, v); check("R2 readback C dout", v, 32'h1234_5678);
    rd(7'h1C, v); check("R2 readback C dir", v, 32'h0000_FFFF);
  endtask

  task automatic t_levels();
    logic [31:0] v;
    pins[63:32] = 32'hDEAD_BEEF;
    pins[127:96] = 32'h0BAD_F00D;
    idle(3);
    rd(7'h54, v); check("R3 level B", v, 32'hDEAD_BEEF);
    rd(7'h5C, v); check("R3 level D", v, 32'h0BAD_F00D);
    wr(7'h54, 32'h0);
    rd(7'h54, v); check("R3 level write ignored", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_level_irq();
    logic [31:0] v;
    wr(7'h38, 32'h0);
    wr(7'h3C, 32'h0000_0008);
    pins[3] = 1'b1; idle(3);
    rd(7'h40, v); check("R5 disabled status", v, 0);
    check("R5 disabled irq", {31'b0, irq}, 0);
    wr(7'h30, 32'h0000_0008); idle(1);
    rd(7'h40, v); check("R4 active high status", v, 32'h8);
    check("R8 irq follows status", {31'b0, irq}, 1);
    pins[3] = 1'b0; idle(3);
    rd(7'h40, v); check("R4 level not latched", v, 0);
    pins[4] = 1'b0;
    wr(7'h30, 32'h0000_0018); idle(1);
    rd(7'h40, v); check("R4 active low status", v, 32'h10);
    pins[4] = 1'b1; idle(3);
    rd(7'h40, v); check("R4 active low released", v, 0);
    wr(7'h30, 32'h0);
  endtask

  task automatic t_edge_irq();
    logic [31:0] v;
    pins[31:0] = 32'h2; idle(4);
    wr(7'h38, 32'h3);
    wr(7'h3C, 32'h1);
    wr(7'h30, 32'h3); idle(2);
    rd(7'h40, v); check("R6 no edge yet", v, 0);
    pins[0] = 1'b1; idle(4);
    rd(7'h40, v); check("R6 rising caught", v, 32'h1);
    check("R8 irq high", {31'b0, irq}, 1);
    pins[0] = 1'b0; idle(4);
    rd(7'h40, v); check("R6 rising latched", v, 32'h1);
    pins[1] = 1'b0; idle(4);
    rd(7'h40, v); check("R6 falling caught", v, 32'h3);
    wr(7'h4C, 32'h0); idle(1);
    rd(7'h40, v); check("R7 zero write keeps", v, 32'h3);
    wr(7'h4C, 32'h1); idle(1);
    rd(7'h40, v); check("R7 clear bit 0", v, 32'h2);
    rd(7'h4C, v); check("R7 eoi reads zero", v, 0);
    wr(7'h34, 32'h2); idle(1);
    rd(7'h40, v); check("R8 masked status", v, 0);
    check("R8 masked irq", {31'b0, irq}, 0);
    wr(7'h34, 32'h0); idle(1);
    rd(7'h40, v); check("R8 unmask restores", v, 32'h2);
    wr(7'h4C, 32'hFFFF_FFFF); idle(1);
    rd(7'h40, v); check("R7 clear all", v, 0);
    check("R7 irq low after clear", {31'b0, irq}, 0);
    wr(7'h30, 32'h0);
  endtask

  task automatic t_debounce();
    logic [31:0] v;
    wr(7'h38, 32'h0);
    wr(7'h3C, 32'h20);
    wr(7'h48, 32'h20);
    wr(7'h30, 32'h20);
    pins[5] = 1'b1; idle(4);
    rd(7'h40, v); check("R9 no tick no change", v, 0);
    tick(); idle(2);
    rd(7'h40, v); check("R9 one tick not enough", v, 0);
    tick(); idle(2);
    rd(7'h40, v); check("R9 two ticks accept", v, 32'h20);
    pins[5] = 1'b0; idle(3);
    tick();
    pins[5] = 1'b1; idle(3);
    tick(); idle(2);
    rd(7'h40, v); check("R9 glitch rejected", v, 32'h20);
    pins[5] = 1'b0; idle(3);
    tick(); tick(); idle(2);
    rd(7'h40, v); check("R9 low accepted", v, 0);
    wr(7'h30, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(7'h60, 32'hFFFF_FFFF);
    rd(7'h60, v); check("R10 unmapped 0x60", v, 0);
    wr(7'h08, 32'hFFFF_FFFF);
    rd(7'h08, v); check("R10 unmapped 0x08", v, 0);
    rd(7'h01, v); check("R10 unaligned", v, 0);
    rd(7'h00, v); check("R10 neighbours kept", v, 32'hA5A5_0F0F);
    wr(7'h40, 32'hFFFF_FFFF);
    rd(7'h40, v); check("R10 status read-only", v, 0);
  endtask

  initial begin
    idle(3);
    presetn = 1'b1;
    idle(1);
    t_reset();
    t_data_dir();
    t_levels();
    t_level_irq();
    t_edge_irq();
    t_debounce();
    t_unmapped();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge pclk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule